// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

This block moves data between a 12-bit narrow port (A) and a 24-bit wide port (B) through clocked storage. The wide port is treated as two 12-bit halves: the low half (B1, bits 11:0) and the high half (B2, bits 23:12). In the narrow-to-wide direction, the B1 half is fed by a two-stage register pipeline and the B2 half by a single register. As a result, two words placed on A on consecutive edges appear together as one 24-bit word on B.

In the wide-to-narrow direction, each half of B has its own capture register. A registered select picks which of the two stored halves drives A.

Every storage register has an active-low capture enable. The direction of each port is set by an active-low output enable, and that enable is registered, so a direction change only happens on a rising clock edge. Tristate pins are modelled as separate input, output and drive-enable signals.

Top module: `bus_exchanger_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, every data register and the select register clear to zero and both registered output enables go inactive. After that edge, `a_out`=0, `b_out`=0, `a_oe`=0 and `b_oe`=0.
- R2: At an edge where `ab1_ce_n` is low, the first B1 stage loads `a_in` and the second B1 stage loads the first. `b_out[11:0]` shows the second stage, so a word taken from A reaches B1 two enabled edges later.
- R3: At an edge where `ab2_ce_n` is low, the B2 register loads `a_in`. It is shown on `b_out[23:12]` after that edge.
- R4: Take word X on A at an edge with only `ab1_ce_n` low, then word Y at the next edge with both `ab1_ce_n` and `ab2_ce_n` low. After that second edge, `b_out` equals {Y, X}: the first word is on bits 11:0 and the second on bits 23:12.
- R5: At an edge where a capture enable is high, its register keeps its value. This holds for both B1 stages, the B2 register and both wide-to-narrow registers.
- R6: At an edge where `ba1_ce_n` is low, the wide-to-narrow B1 register loads `b_in[11:0]`. At an edge where `ba2_ce_n` is low, the B2 register loads `b_in[23:12]`.
- R7: `sel` is registered on each rising edge. When the registered value is 0, `a_out` shows the stored B1 half; when it is 1, `a_out` shows the stored B2 half.
- R8: `a_oe` equals the inverse of `oea_n` as sampled at the last rising edge, and `b_oe` equals the inverse of `oeb_n` in the same way. An input change between edges has no effect on either.
- R9: When a port's drive enable is low, the bus is released but the stored data is kept. After the enable is asserted again, the port shows the same data, provided no capture took place in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 12 | Narrow bus value read from the pins |
| a_out | output | 12 | Narrow bus value to drive onto the pins |
| a_oe | output | 1 | Narrow bus drive enable, active high |
| b_in | input | 24 | Wide bus value read from the pins (B2 = 23:12, B1 = 11:0) |
| b_out | output | 24 | Wide bus value to drive onto the pins |
| b_oe | output | 1 | Wide bus drive enable, active high |
| ab1_ce_n | input | 1 | Capture enable for the B1 pipeline, active low |
| ab2_ce_n | input | 1 | Capture enable for the B2 register, active low |
| ba1_ce_n | input | 1 | Capture enable for the B1-to-A register, active low |
| ba2_ce_n | input | 1 | Capture enable for the B2-to-A register, active low |
| sel | input | 1 | Select for A: 0 = B1 store, 1 = B2 store |
| oea_n | input | 1 | Narrow port output enable, active low, registered |
| oeb_n | input | 1 | Wide port output enable, active low, registered |

## Verification
Captures in both directions, a change of select and a change of either output enable can all take effect at the same edge. Random cycles set all four capture enables, the select and both output enables independently each cycle, so these events often coincide. After every edge, each output is compared with a model in the bench that follows the requirements. Directed sequences then cover word pairing, enables held high, and release followed by re-drive.

// File: rtl/bx_pkg.sv
package bx_pkg;
    localparam int unsigned BX_HALF_W = 12;

    typedef struct packed {
        logic oea_q;
        logic oeb_q;
    } dir_t;

    localparam dir_t DIR_RESET = '{oea_q: 1'b1, oeb_q: 1'b1};
endpackage

// File: rtl/bx_a2b_path.sv
module bx_a2b_path #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_i,
    input  logic         ce1_n,
    input  logic         ce2_n,
    output logic [W-1:0] b1_o,
    output logic [W-1:0] b2_o
);
    typedef struct packed {
        logic [W-1:0] stg1;
        logic [W-1:0] stg2;
        logic [W-1:0] hi;
    } a2b_t;

    a2b_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!ce1_n) begin
            st_d.stg1 = a_i;
            st_d.stg2 = st_q.stg1;
        end
        if (!ce2_n) begin
            st_d.hi = a_i;
        end
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign b1_o = st_q.stg2;
    assign b2_o = st_q.hi;

    AST_HI_LOADS_A: assert property (@(posedge clk) disable iff (!rst_n)
        !ce2_n |=> b2_o == $past(a_i)); // R3
    AST_LO_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ce1_n |=> $stable(b1_o)); // R5
    AST_HI_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ce2_n |=> $stable(b2_o)); // R5
endmodule

// File: rtl/bx_b2a_path.sv
module bx_b2a_path #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] b1_i,
    input  logic [W-1:0] b2_i,
    input  logic         ce1_n,
    input  logic         ce2_n,
    input  logic         sel_i,
    output logic [W-1:0] a_o
);
    localparam int unsigned HALVES = 2;

    typedef struct packed {
        logic [HALVES-1:0][W-1:0] store;
        logic                     sel;
    } b2a_t;

    b2a_t st_d, st_q;
    logic [HALVES-1:0][W-1:0] half_in;
    logic [HALVES-1:0]        half_ce_n;

    assign half_in   = {b2_i, b1_i};
    assign half_ce_n = {ce2_n, ce1_n};

    always_comb begin
        st_d     = st_q;
        st_d.sel = sel_i;
        for (int h = 0; h < HALVES; h++) begin
            if (!half_ce_n[h]) begin
                st_d.store[h] = half_in[h];
            end
        end
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign a_o = st_q.store[st_q.sel];

    AST_B1_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce1_n && !sel_i) |=> a_o == $past(b1_i)); // R6
    AST_B2_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce2_n && sel_i) |=> a_o == $past(b2_i)); // R7
    AST_A_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ce1_n && ce2_n && sel_i == st_q.sel) |=> $stable(a_o)); // R5
endmodule

// File: rtl/bx_dir_ctrl.sv
module bx_dir_ctrl
    import bx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic oea_n,
    input  logic oeb_n,
    output logic a_oe,
    output logic b_oe
);
    dir_t st_d, st_q;

    always_comb begin
        st_d.oea_q = oea_n;
        st_d.oeb_q = oeb_n;
        if (!rst_n) begin
            st_d = DIR_RESET;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign a_oe = ~st_q.oea_q;
    assign b_oe = ~st_q.oeb_q;

    AST_OEA_SAMPLED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> a_oe == !$past(oea_n)); // R8
    AST_OEB_SAMPLED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> b_oe == !$past(oeb_n)); // R8
endmodule

// File: rtl/bus_exchanger_top.sv
module bus_exchanger_top
    import bx_pkg::*;
#(
    parameter int unsigned HALF_W = BX_HALF_W,
    localparam int unsigned WIDE_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] a_in,
    output logic [HALF_W-1:0] a_out,
    output logic              a_oe,
    input  logic [WIDE_W-1:0] b_in,
    output logic [WIDE_W-1:0] b_out,
    output logic              b_oe,
    input  logic              ab1_ce_n,
    input  logic              ab2_ce_n,
    input  logic              ba1_ce_n,
    input  logic              ba2_ce_n,
    input  logic              sel,
    input  logic              oea_n,
    input  logic              oeb_n
);
    logic [HALF_W-1:0] b_lo, b_hi;

    bx_a2b_path #(.W(HALF_W)) u_a2b (
        .clk   (clk),
        .rst_n (rst_n),
        .a_i   (a_in),
        .ce1_n (ab1_ce_n),
        .ce2_n (ab2_ce_n),
        .b1_o  (b_lo),
        .b2_o  (b_hi)
    );

    bx_b2a_path #(.W(HALF_W)) u_b2a (
        .clk   (clk),
        .rst_n (rst_n),
        .b1_i  (b_in[HALF_W-1:0]),
        .b2_i  (b_in[WIDE_W-1:HALF_W]),
        .ce1_n (ba1_ce_n),
        .ce2_n (ba2_ce_n),
        .sel_i (sel),
        .a_o   (a_out)
    );

    bx_dir_ctrl u_dir (
        .clk   (clk),
        .rst_n (rst_n),
        .oea_n (oea_n),
        .oeb_n (oeb_n),
        .a_oe  (a_oe),
        .b_oe  (b_oe)
    );

    assign b_out = {b_hi, b_lo};

    AST_PAIR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab1_ce_n && !ab2_ce_n) |=> b_out[WIDE_W-1:HALF_W] == $past(a_in)); // R4
endmodule

// File: tb/bus_exchanger_top_tb_top.sv
module bus_exchanger_top_tb_top;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned HW = 12;

    logic clk = 1'b0;
    logic rst_n;
    logic [HW-1:0]   a_in, a_out;
    logic [2*HW-1:0] b_in, b_out;
    logic a_oe, b_oe;
    logic ab1_ce_n, ab2_ce_n, ba1_ce_n, ba2_ce_n, sel, oea_n, oeb_n;

    int total = 0;
    int bad = 0;

    logic [HW-1:0] m_s1, m_s2, m_hi, m_r1, m_r2;
    logic m_sel, m_oea, m_oeb;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_exchanger_top dut_i (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .ab1_ce_n(ab1_ce_n), .ab2_ce_n(ab2_ce_n),
        .ba1_ce_n(ba1_ce_n), .ba2_ce_n(ba2_ce_n),
        .sel(sel), .oea_n(oea_n), .oeb_n(oeb_n)
    );

    function automatic logic [2*HW-1:0] exp_b();
        return {m_hi, m_s2};
    endfunction

    function automatic logic [HW-1:0] exp_a();
        return m_sel ? m_r2 : m_r1;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        ab1_ce_n = 1'b1; ab2_ce_n = 1'b1; ba1_ce_n = 1'b1; ba2_ce_n = 1'b1;
    endtask

    // One edge: update the model from the driven inputs, then compare.
    task automatic cycle();
        @(posedge clk);
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_hi = '0; m_r1 = '0; m_r2 = '0;
            m_sel = 1'b0; m_oea = 1'b1; m_oeb = 1'b1;
        end else begin
            if (!ab1_ce_n) begin m_s2 = m_s1; m_s1 = a_in; end
            if (!ab2_ce_n) m_hi = a_in;
            if (!ba1_ce_n) m_r1 = b_in[HW-1:0];
            if (!ba2_ce_n) m_r2 = b_in[2*HW-1:HW];
            m_sel = sel; m_oea = oea_n; m_oeb = oeb_n;
        end
        #1;
        chk("R2 b_out low half", 32'(b_out[HW-1:0]), 32'(m_s2));
        chk("R3 b_out high half", 32'(b_out[2*HW-1:HW]), 32'(m_hi));
        chk("R7 a_out", 32'(a_out), 32'(exp_a()));
        chk("R8 a_oe", 32'(a_oe), 32'(!m_oea));
        chk("R8 b_oe", 32'(b_oe), 32'(!m_oeb));
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        logic [HW-1:0] w0, w1;
        logic [2*HW-1:0] keep_b;
        logic [HW-1:0] keep_a;
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; a_in = 12'hFFF; b_in = 24'hFFFFFF; sel = 1'b1;
        oea_n = 1'b0; oeb_n = 1'b0; ab1_ce_n = 1'b0; ab2_ce_n = 1'b0;
        ba1_ce_n = 1'b0; ba2_ce_n = 1'b0;
        @(negedge clk);
        cycle();
        // R1: reset state
        chk("R1 b_out", 32'(b_out), 32'h0);
        chk("R1 a_out", 32'(a_out), 32'h0);
        chk("R1 oe pair", 32'({a_oe, b_oe}), 32'h0);
        rst_n = 1'b1; idle(); oea_n = 1'b1; oeb_n = 1'b0; sel = 1'b0;

        // R4: pairing of two sequential words
        w0 = 12'h3A5; w1 = 12'hC5A;
        a_in = w0; ab1_ce_n = 1'b0; cycle();
        a_in = w1; ab1_ce_n = 1'b0; ab2_ce_n = 1'b0; cycle();
        chk("R4 paired word", 32'(b_out), 32'({w1, w0}));

        // R5: enables high freeze everything
        idle(); keep_b = b_out; keep_a = a_out;
        for (int i = 0; i < 3; i++) begin
            a_in = 12'($urandom); b_in = 24'($urandom); cycle();
        end
        chk("R5 b_out held", 32'(b_out), 32'(keep_b));
        chk("R5 a_out held", 32'(a_out), 32'(keep_a));

        // R6: wide-to-narrow captures with select
        b_in = 24'hABC_123; ba1_ce_n = 1'b0; sel = 1'b0; oea_n = 1'b0; cycle();
        chk("R6 B1 to A", 32'(a_out), 32'h123);
        idle(); b_in = 24'h456_789; ba2_ce_n = 1'b0; sel = 1'b1; cycle();
        chk("R6 B2 to A", 32'(a_out), 32'h456);
        idle(); sel = 1'b0; cycle();
        chk("R7 select back to B1", 32'(a_out), 32'h123);

        // R9: release and re-drive keeps data
        keep_b = b_out; oeb_n = 1'b1; cycle();
        chk("R9 b released", 32'(b_oe), 32'h0);
        oeb_n = 1'b0; cycle();
        chk("R9 b re-driven", 32'(b_oe), 32'h1);
        chk("R9 data kept", 32'(b_out), 32'(keep_b));

        // R8: change between edges has no effect until next edge
        oea_n = 1'b1; #2;
        chk("R8 no change before edge", 32'(a_oe), 32'h1);
        cycle();

        // random mix
        for (int n = 0; n < 600; n++) begin
            a_in = 12'($urandom); b_in = 24'($urandom);
            ab1_ce_n = 1'($urandom); ab2_ce_n = 1'($urandom);
            ba1_ce_n = 1'($urandom); ba2_ce_n = 1'($urandom);
            sel = 1'($urandom); oea_n = 1'($urandom); oeb_n = 1'($urandom);
            rst_n = ($urandom % 97) != 0;
            cycle();
        end
        rst_n = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule